// File: doc/BRIEF.md
# Peripheral-Paced Byte Transfer Channel

This block is one DMA channel. It copies bytes between a fixed peripheral data register and a run of memory locations. Software programs the channel through a small register write port: a peripheral address, a memory start address, a transfer count, and a control word. The control word holds the direction, a two-bit priority, two interrupt enables and the enable bit. Once enabled, the channel waits for the peripheral to raise its request line. For each request it performs one byte move on a valid/ready memory port: a read from the source, then a write to the destination. It then acknowledges the peripheral, steps the memory address and lowers the remaining count.

When the last programmed byte has moved, the channel pulses an end-of-transfer line to the peripheral, clears its own enable and sets a sticky completion flag. For transfers from the peripheral into memory, a second pulse line fires when the next-to-last byte completes. A receiving peripheral can use that pulse to prepare its final-byte handling. A half-way flag and a full flag each feed the interrupt output through their own enable. Both flags are cleared by writing ones to a clear register.

Top module: `pdma_channel`

## Requirements
- R1: After reset the channel is disabled, the remaining count is 0, both flags and `irq` are low, and the bus port is idle.
- R2: Control word layout at register 0: bit 0 enable, bit 1 direction (1 = memory to peripheral, 0 = peripheral to memory), bit 2 half-way interrupt enable, bit 3 full interrupt enable, bits 5:4 priority. Register 1 is the peripheral address, register 2 the memory start address, register 3 the count. Setting enable while the count is 0 is rejected: the channel stays disabled and starts no transfer.
- R3: Each serviced request reads one byte from the source address and writes the same byte to the destination address. The direction bit selects which address is the source.
- R4: The memory address rises by one after every transfer, and the peripheral address never changes.
- R5: The remaining count drops by exactly one per serviced request. `per_ack` pulses for one cycle after each transfer, in the cycle the new count is visible.
- R6: When the count reaches 0, `per_eot` pulses once, in the same cycle as that final `per_ack`. The enable clears, and later requests start no bus activity and get no acknowledge.
- R7: In peripheral-to-memory mode with a count of at least 2, `per_eot_m1` pulses once, when the count falls from 2 to 1. It never pulses in the other direction.
- R8: `ht_flag` sets after the first transfer that leaves the remaining count at or below half of the programmed count, rounded down.
- R9: `tc_flag` sets at completion. Both flags hold until a write to register 4 with bit 0 (half-way flag) or bit 1 (full flag) set. `irq` is high when an enabled flag is set.
- R10: While the channel is enabled, writes to registers 0 to 3 have no effect.
- R11: A bus request holds its address and direction stable until `bus_ready` is seen.
- R12: The priority field written to bits 5:4 of register 0 appears on `prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| ch_en | output | 1 | Channel enabled |
| prio | output | 2 | Stored priority level |
| remaining | output | CW | Transfers still to do |
| ht_flag | output | 1 | Half-way flag |
| tc_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| per_req | input | 1 | Peripheral request, held until acknowledged |
| per_ack | output | 1 | One-cycle acknowledge per transfer |
| per_eot | output | 1 | End-of-transfer pulse |
| per_eot_m1 | output | 1 | Next-to-last transfer pulse |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| bus_ready | input | 1 | Bus accepts or returns data |

## Verification
The hardest cases are at the count boundaries: the next-to-last pulse, the half-way crossing and the final pulse. Each must fire in exactly the right transfer, while bus stalls move the moment each transfer finishes. The stimulus sweeps every count from 0 to 6 in both directions. The memory responder withholds `bus_ready` on a rotating pattern, so each boundary transfer meets a different stall phase. For odd and even totals, the bench computes the expected count, flag state and pulse totals from the transfer index.

// File: rtl/pdma_channel.sv
module pdma_channel #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          ch_en,
  output logic [1:0]    prio,
  output logic [CW-1:0] remaining,
  output logic          ht_flag,
  output logic          tc_flag,
  output logic          irq,
  input  logic          per_req,
  output logic          per_ack,
  output logic          per_eot,
  output logic          per_eot_m1,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ready
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_ACK} state_t;

  state_t        state;
  logic          en, dir, hie, tie;
  logic [1:0]    prio_q;
  logic [AW-1:0] paddr, maddr;
  logic [CW-1:0] cnt, total;
  logic [7:0]    hold;
  logic          ht, tc, eot_q, eotm1_q;

  logic [CW-1:0] cnt_dec, half;
  assign cnt_dec = cnt - 1'b1;
  assign half    = total >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      en      <= 1'b0;
      dir     <= 1'b0;
      hie     <= 1'b0;
      tie     <= 1'b0;
      prio_q  <= '0;
      paddr   <= '0;
      maddr   <= '0;
      cnt     <= '0;
      total   <= '0;
      hold    <= '0;
      ht      <= 1'b0;
      tc      <= 1'b0;
      eot_q   <= 1'b0;
      eotm1_q <= 1'b0;
    end else begin
      eot_q   <= 1'b0;
      eotm1_q <= 1'b0;

      if (cfg_we) begin
        case (cfg_addr)
          3'd0: if (!en) begin
            dir    <= cfg_wdata[1];
            hie    <= cfg_wdata[2];
            tie    <= cfg_wdata[3];
            prio_q <= cfg_wdata[5:4];
            en     <= cfg_wdata[0] && (cnt != '0);
            total  <= cnt;
          end
          3'd1: if (!en) paddr <= cfg_wdata[AW-1:0];
          3'd2: if (!en) maddr <= cfg_wdata[AW-1:0];
          3'd3: if (!en) cnt <= cfg_wdata[CW-1:0];
          3'd4: begin
            if (cfg_wdata[0]) ht <= 1'b0;
            if (cfg_wdata[1]) tc <= 1'b0;
          end
          default: ;
        endcase
      end

      case (state)
        S_IDLE: if (en && per_req) state <= S_RD;
        S_RD: if (bus_ready) begin
          hold  <= bus_rdata;
          state <= S_WR;
        end
        S_WR: if (bus_ready) begin
          maddr <= maddr + 1'b1;
          cnt   <= cnt_dec;
          state <= S_ACK;
          if (cnt == CW'(1)) begin
            en    <= 1'b0;
            tc    <= 1'b1;
            eot_q <= 1'b1;
          end
          if (cnt == CW'(2) && !dir) eotm1_q <= 1'b1;
          if (cnt_dec <= half && cnt > half) ht <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_valid  = (state == S_RD) || (state == S_WR);
  assign bus_write  = (state == S_WR);
  assign bus_addr   = ((state == S_RD) == dir) ? maddr : paddr;
  assign bus_wdata  = hold;
  assign per_ack    = (state == S_ACK);
  assign per_eot    = eot_q;
  assign per_eot_m1 = eotm1_q;
  assign ch_en      = en;
  assign prio       = prio_q;
  assign remaining  = cnt;
  assign ht_flag    = ht;
  assign tc_flag    = tc;
  assign irq        = (ht && hie) || (tc && tie);

endmodule

module pdma_channel_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ch_en,
  input logic [CW-1:0] remaining,
  input logic          per_ack,
  input logic          per_eot,
  input logic          per_eot_m1,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ready
);

  assert_eot_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    per_eot |-> (remaining == '0) && !ch_en);

  assert_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !bus_valid);

  assert_eotm1_at_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    per_eot_m1 |-> (remaining == CW'(1)));

  assert_pulses_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_eot && per_eot_m1));

  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en |=> (remaining == $past(remaining)) || (remaining == CW'($past(remaining) - 1'b1)));

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

endmodule

bind pdma_channel pdma_channel_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .remaining(remaining),
  .per_ack(per_ack), .per_eot(per_eot), .per_eot_m1(per_eot_m1),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_ready(bus_ready)
);

// File: tb/pdma_channel_tb.sv
module pdma_channel_tb_top;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;
  localparam logic [7:0] PADDR = 8'hF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          ch_en, ht_flag, tc_flag, irq;
  logic [1:0]    prio;
  logic [CW-1:0] remaining;
  logic          per_req = 1'b0;
  logic          per_ack, per_eot, per_eot_m1;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = '0;
  logic          bus_ready = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pdma_channel #(.AW(AW), .CW(CW), .DW(DW)) dut_i (.*);

  logic [7:0] mem [0:255];
  logic [7:0] per_src = '0;
  logic [7:0] per_sink;
  int stall = 0;
  int n_eot = 0, n_eotm1 = 0, n_ack = 0, n_valid = 0;

  function automatic logic [7:0] src_fn(input logic [7:0] a);
    return 8'((a * 13) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] pat(input int n, input int d, input int j);
    return 8'(n * 37 + j * 11 + d * 5 + 1);
  endfunction

  always @(negedge clk) begin
    stall++;
    if (bus_valid && (stall % 3 != 1)) begin
      bus_ready = 1'b1;
      if (bus_write) begin
        if (bus_addr[7:0] == PADDR) per_sink = bus_wdata;
        else mem[bus_addr[7:0]] = bus_wdata;
      end else begin
        bus_rdata = (bus_addr[7:0] == PADDR) ? per_src : src_fn(bus_addr[7:0]);
      end
    end else begin
      bus_ready = 1'b0;
    end
    if (per_eot) n_eot++;
    if (per_eot_m1) n_eotm1++;
    if (per_ack) n_ack++;
    if (bus_valid) n_valid++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 en", int'(ch_en), 0);
    chk("R1 count", int'(remaining), 0);
    chk("R1 flags", int'({ht_flag, tc_flag, irq}), 0);
    chk("R1 bus", int'(bus_valid), 0);

    for (int n = 0; n <= 6; n++) begin
      for (int d = 0; d <= 1; d++) begin
        int base, hie, tie, pr, e0, m0, a0, v0, hexp, texp;
        base = 16 + n * 16 + d * 8;
        hie = n % 2;
        tie = d ^ ((n / 2) % 2);
        pr = (n + 3 * d) % 4;
        cfg_wr(3'd1, DW'(PADDR));
        cfg_wr(3'd2, DW'(base));
        cfg_wr(3'd3, DW'(n));
        e0 = n_eot; m0 = n_eotm1; a0 = n_ack;
        cfg_wr(3'd0, DW'((pr << 4) | (tie << 3) | (hie << 2) | (d << 1) | 1));
        chk("R12 prio", int'(prio), pr);
        chk("R2 enable", int'(ch_en), (n != 0) ? 1 : 0);
        chk("R5 initial count", int'(remaining), n);
        if (n > 0) begin
          cfg_wr(3'd3, DW'(99));
          cfg_wr(3'd2, DW'(200));
          cfg_wr(3'd0, DW'({d == 0, 1'b1}));
          chk("R10 count kept", int'(remaining), n);
        end
        for (int j = 1; j <= n; j++) begin
          int w;
          per_src = pat(n, d, j);
          @(negedge clk);
          per_req = 1'b1;
          w = 0;
          do begin
            @(negedge clk);
            w++;
          end while (!per_ack && w < 60);
          per_req = 1'b0;
          chk("R5 ack seen", int'(per_ack), 1);
          chk("R5 count", int'(remaining), n - j);
          hexp = ((n - j) <= n / 2) ? 1 : 0;
          texp = (j == n) ? 1 : 0;
          chk("R8 half flag", int'(ht_flag), hexp);
          chk("R9 full flag", int'(tc_flag), texp);
          chk("R9 irq", int'(irq), ((hexp & hie) | (texp & tie)));
          chk("R6 enable", int'(ch_en), (j < n) ? 1 : 0);
          chk("R6 eot timing", int'(per_eot), texp);
          if (d == 1) chk("R3 R4 sink", int'(per_sink), int'(src_fn(8'(base + j - 1))));
        end
        repeat (2) @(negedge clk);
        chk("R6 eot count", n_eot - e0, (n > 0) ? 1 : 0);
        chk("R7 eot_m1 count", n_eotm1 - m0, (d == 0 && n >= 2) ? 1 : 0);
        chk("R5 ack count", n_ack - a0, n);
        if (d == 0)
          for (int j = 1; j <= n; j++)
            chk("R3 R4 mem", int'(mem[8'(base + j - 1)]), int'(pat(n, d, j)));
        a0 = n_ack; v0 = n_valid;
        per_req = 1'b1;
        repeat (10) @(negedge clk);
        per_req = 1'b0;
        chk("R6 ignored ack", n_ack - a0, 0);
        chk("R6 ignored bus", n_valid - v0, 0);
        chk("R6 count held", int'(remaining), 0);
        if (n > 0) begin
          cfg_wr(3'd4, DW'(1));
          chk("R9 clear half", int'({ht_flag, tc_flag}), 1);
          cfg_wr(3'd4, DW'(2));
          chk("R9 clear full", int'({ht_flag, tc_flag, irq}), 0);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule